// File: doc/BRIEF.md
# Segmented Sticky Interrupt Vector

This block collects the interrupt conditions of a time-triggered CAN controller into a 16-bit status vector. The vector is made of four segments of four bits each, ordered by severity: fatal errors in the lowest segment, then disturbance errors, then time and notification events, then schedule synchronisation events. The controller core raises a bit with a one-cycle event pulse. The bit then stays set until software clears it by writing a zero to that position.

A 16-bit enable register gates each status bit on its own. The enabled bits are ORed into one registered interrupt line. A second registered line reports that an enabled fatal-error bit is pending. Software reaches both registers through a small single-address-bit read/write port. Reads are combinational and return the current register contents.

Top module: `ttIrqVector`

## Requirements
- R1: While reset is asserted, the status register, the enable register, `irqOut` and `fatalPending` are all zero.
- R2: A 1 on `eventPulse[i]` at a clock edge sets status bit i, and reads at address 0 show it from then on. The bit map is as follows. Bits 3:0 are the fatal segment: configuration error (0), application watchdog (1), watch trigger reached (2), initialisation watch trigger (3). Bits 7:4 are the disturbance segment: error level change, Tx overflow, Tx underflow, global time error. Bits 11:8 are the event segment: discontinuity, global time wrap, stop-watch event, time mark. Bits 15:12 are the schedule segment: gap, cycle start, matrix start, basic cycle start.
- R3: A write to address 0 clears exactly the status bits whose write-data bit is 0. Without such a write, a set status bit stays set.
- R4: Writing a 1 to a status bit has no effect. A clear bit stays clear and a set bit stays set.
- R5: When an event pulse and a write of 0 reach the same status bit in the same cycle, the bit ends up set.
- R6: A write to address 1 loads the enable register with the write data. Reads at address 1 return the enable register, and reads at address 0 return the status register.
- R7: `irqOut` is registered. After each clock edge it equals the OR over all bits of (status AND enable), as those registers held just before that edge.
- R8: `fatalPending` is registered. After each clock edge it equals the OR over bits 3:0 of (status AND enable), as those registers held just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eventPulse | input | 16 | One-cycle set pulses from the controller core |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the addressed register |
| irqOut | output | 1 | Registered OR of enabled status bits |
| fatalPending | output | 1 | Registered OR of enabled fatal-segment bits |

## Verification
The collision that matters is a hardware event pulse landing on a bit in the same cycle that software writes a 0 to that bit. The bench provokes it on purpose with directed steps. It also produces it many times over in a random phase, where write data and pulse patterns overlap freely. Each case is judged by reading the status back the following cycle and comparing it against a behavioural model in which the set always follows the clear. A second overlap, an enable write in the same cycle as a status change, is judged through the one-cycle lag of both interrupt outputs.

// File: rtl/ttIrqPkg.sv
package ttIrqPkg;
  localparam int DEF_SEG_COUNT = 4;
  localparam int DEF_SEG_WIDTH = 4;
  localparam int DEF_FATAL_SEG = 0;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import ttIrqPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regAddr,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.wrStatus = regWrEn && (regAddr == ADDR_STATUS);
    strobes.wrEnable = regWrEn && (regAddr == ADDR_ENABLE);
  end

  // R6: a single write targets at most one register
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrStatus, strobes.wrEnable}));
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import ttIrqPkg::*;
#(
  parameter int SEG_COUNT = DEF_SEG_COUNT,
  parameter int SEG_WIDTH = DEF_SEG_WIDTH,
  parameter int FATAL_SEG = DEF_FATAL_SEG
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [SEG_COUNT*SEG_WIDTH-1:0] eventPulse,
  input  logic                           regAddr,
  input  logic [SEG_COUNT*SEG_WIDTH-1:0] regWrData,
  output logic [SEG_COUNT*SEG_WIDTH-1:0] regRdData,
  output logic                           irqOut,
  output logic                           fatalPending
);
  localparam int VEC_W = SEG_COUNT * SEG_WIDTH;

  logic [VEC_W-1:0] statusQ;
  logic [VEC_W-1:0] enableQ;
  logic [VEC_W-1:0] maskedVec;

  genvar seg;
  generate
    for (seg = 0; seg < SEG_COUNT; seg++) begin : gSeg
      logic [SEG_WIDTH-1:0] keepMask;
      logic [SEG_WIDTH-1:0] segEvents;
      assign segEvents = eventPulse[seg*SEG_WIDTH +: SEG_WIDTH];
      assign keepMask  = strobes.wrStatus ? regWrData[seg*SEG_WIDTH +: SEG_WIDTH]
                                          : {SEG_WIDTH{1'b1}};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusQ[seg*SEG_WIDTH +: SEG_WIDTH] <= '0;
        end else begin
          statusQ[seg*SEG_WIDTH +: SEG_WIDTH] <=
            (statusQ[seg*SEG_WIDTH +: SEG_WIDTH] & keepMask) | segEvents;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobes.wrEnable) begin
      enableQ <= regWrData;
    end
  end

  assign maskedVec = statusQ & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut       <= 1'b0;
      fatalPending <= 1'b0;
    end else begin
      irqOut       <= |maskedVec;
      fatalPending <= |maskedVec[FATAL_SEG*SEG_WIDTH +: SEG_WIDTH];
    end
  end

  assign regRdData = (regAddr == ADDR_ENABLE) ? enableQ : statusQ;

  // R3: without a status write no set bit is lost
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R2 and R5: every pulsed bit is set one edge later, whatever the write did
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|eventPulse) |=> ((statusQ & $past(eventPulse)) == $past(eventPulse)));

  // R4: with no events, a status write never creates a set bit
  assert_write_one_inert_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStatus && eventPulse == '0) |=> ((statusQ & ~$past(statusQ)) == '0));

  // R7: the line follows the enabled status with one edge of lag
  assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusQ & enableQ))));

  // R8: a fatal indication is always also an interrupt
  assert_fatal_implies_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    fatalPending |-> irqOut);
endmodule

// File: rtl/ttIrqVector.sv
module ttIrqVector
  import ttIrqPkg::*;
#(
  parameter int SEG_COUNT = DEF_SEG_COUNT,
  parameter int SEG_WIDTH = DEF_SEG_WIDTH,
  parameter int FATAL_SEG = DEF_FATAL_SEG
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [SEG_COUNT*SEG_WIDTH-1:0] eventPulse,
  input  logic                           regWrEn,
  input  logic                           regAddr,
  input  logic [SEG_COUNT*SEG_WIDTH-1:0] regWrData,
  output logic [SEG_COUNT*SEG_WIDTH-1:0] regRdData,
  output logic                           irqOut,
  output logic                           fatalPending
);
  ctrlStrobes_t strobes;

  irqCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irqDatapath #(
    .SEG_COUNT (SEG_COUNT),
    .SEG_WIDTH (SEG_WIDTH),
    .FATAL_SEG (FATAL_SEG)
  ) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .eventPulse   (eventPulse),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .irqOut       (irqOut),
    .fatalPending (fatalPending)
  );
endmodule

// File: tb/tb_ttIrqVector.sv
`timescale 1ns/1ps
module tb_ttIrqVector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] eventPulse = '0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;
  logic        fatalPending;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  logic [15:0] mStatus = '0;
  logic [15:0] mEnable = '0;
  logic        mIrq = 1'b0;
  logic        mFatal = 1'b0;

  always #2 clk = ~clk;

  ttIrqVector dut (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .fatalPending(fatalPending)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStatus = '0; mEnable = '0; mIrq = 0; mFatal = 0;
    end else begin
      logic nIrq, nFatal;
      nIrq   = (mStatus & mEnable) != 0;
      nFatal = (mStatus[3:0] & mEnable[3:0]) != 0;
      if (regWrEn && regAddr == 1'b0) mStatus = mStatus & regWrData;
      if (regWrEn && regAddr == 1'b1) mEnable = regWrData;
      mStatus = mStatus | eventPulse;
      mIrq = nIrq;
      mFatal = nFatal;
    end
  end

  task automatic checkEq(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareModel();
    logic [15:0] expRd;
    expRd = regAddr ? mEnable : mStatus;
    checkEq(curReq, "read data", regRdData, expRd);
    checkEq(curReq, "irqOut", {15'd0, irqOut}, {15'd0, mIrq});
    checkEq(curReq, "fatalPending", {15'd0, fatalPending}, {15'd0, mFatal});
  endtask

  // one cycle: check at negedge, then apply the next stimulus
  task automatic step(logic [15:0] ev, logic we, logic a, logic [15:0] d);
    @(negedge clk);
    compareModel();
    eventPulse = ev; regWrEn = we; regAddr = a; regWrData = d;
  endtask

  task automatic idle(logic a, int n);
    for (int k = 0; k < n; k++) step('0, 0, a, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    curReq = "R1";
    idle(0, 2);
    @(negedge clk);
    checkEq("R1", "status in reset", regRdData, 16'h0000);
    checkEq("R1", "irq in reset", {15'd0, irqOut}, 16'h0);
    checkEq("R1", "fatal in reset", {15'd0, fatalPending}, 16'h0);
    regAddr = 1;
    #0;
    checkEq("R1", "enable in reset", regRdData, 16'h0000);
    rstN = 1;
    idle(0, 2);

    // R2 pulse each bit position in turn
    curReq = "R2";
    for (int i = 0; i < 16; i++) step(16'h1 << i, 0, 0, '0);
    idle(0, 1);
    checkEq("R2", "all bits set", regRdData, 16'hFFFF);

    // R3 clear only the fatal segment, then everything
    curReq = "R3";
    step('0, 1, 0, 16'hFFF0);
    idle(0, 1);
    checkEq("R3", "fatal segment cleared", regRdData, 16'hFFF0);
    idle(0, 3);
    checkEq("R3", "bits held", regRdData, 16'hFFF0);
    step('0, 1, 0, 16'h0000);
    idle(0, 1);

    // R4 writing ones is inert
    curReq = "R4";
    step('0, 1, 0, 16'hFFFF);
    idle(0, 1);
    checkEq("R4", "ones on clear vector", regRdData, 16'h0000);
    step(16'hA5A5, 0, 0, '0);
    step('0, 1, 0, 16'hFFFF);
    idle(0, 1);
    checkEq("R4", "ones on set vector", regRdData, 16'hA5A5);

    // R5 event and write-0 on the same bit
    curReq = "R5";
    step(16'h0024, 1, 0, 16'h0000);
    idle(0, 1);
    checkEq("R5", "event beats clear", regRdData, 16'h0024);
    step('0, 1, 0, 16'h0000);

    // R6 enable register
    curReq = "R6";
    step('0, 1, 1, 16'h00F0);
    idle(1, 1);
    checkEq("R6", "enable readback", regRdData, 16'h00F0);

    // R7 enabled non-fatal bit raises irq one edge later
    curReq = "R7";
    step(16'h0010, 0, 0, '0);
    idle(0, 3);
    checkEq("R7", "irq from bit 4", {15'd0, irqOut}, 16'h1);
    checkEq("R8", "no fatal from bit 4", {15'd0, fatalPending}, 16'h0);
    step(16'h0001, 0, 0, '0);
    idle(0, 2);
    checkEq("R7", "disabled bit 0 set", regRdData, 16'h0011);

    // R8 enable fatal bits
    curReq = "R8";
    step('0, 1, 1, 16'h000F);
    idle(0, 3);
    checkEq("R8", "fatal from bit 0", {15'd0, fatalPending}, 16'h1);
    step('0, 1, 0, 16'hFFFE);
    idle(0, 3);
    checkEq("R8", "fatal gone after clear", {15'd0, fatalPending}, 16'h0);

    // random overlap of events, clears and enable writes
    curReq = "R5 random";
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      step(ev, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           16'($urandom) | 16'($urandom));
    end
    idle(0, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule